// File: doc/BRIEF.md
# PMIC Serial Bus Command Front-End

This block is the register front-end for one channel of a controller that talks to power-management chips over a serial bus. Software uses an APB port to fill four 32-bit payload words. It then writes a command word that has its start bit set. The block splits that word into opcode, target id, register address and byte count. It presents these fields, with the payload, to a back-end bus engine as a request that stays raised until the engine acknowledges it.

When the engine acknowledges, the block records the result for the target that was addressed. The done and failed flags go into a per-target status word. For read opcodes, the returned bytes go into that target's four read-data words. Each target id has its own status and read-data bank at a fixed stride, so results for different targets never overwrite each other.

Each channel's register window sits at a multiple of 0x300 chosen by a channel parameter. The block ignores any access outside its window. The APB access never waits.

Top module: `pmic_cmd_frontend`

## Requirements
- R1: After reset every register reads as zero and `req_valid` is low.
- R2: The payload words sit at window offsets 0x104, 0x108, 0x10C and 0x110 and read back what was last written. Offset 0x100 reads back the last accepted command word. `pready` is always high.
- R3: A write to offset 0x100 with bit 31 set, while idle, raises `req_valid` at the next clock. The request fields come from the command word: opcode from bits 27:24, byte count minus one from bits 23:20, target id from bits 19:16, address from bits 15:0. `req_wbytes` is the four payload words concatenated, with word 0 in bits 127:96, so the first payload byte is in bits 127:120. A command write with bit 31 clear has no effect.
- R4: All request outputs hold steady while `req_valid` is high and `rsp_ack` is low. `req_valid` is low in the cycle after an acknowledge.
- R5: While a request is pending, writes to the command word and to the payload words are ignored.
- R6: The status word of target N is at window offset 0x200+0x20*N. Bit 0 is done and bit 2 is failed. Starting a command clears both bits for its target. On acknowledge, done is set and failed takes the value of `rsp_fail`. The status of other targets is not changed.
- R7: The read opcodes are 2, 4 and 6. When one of them completes, `rsp_rbytes` is stored into the target's words at window offsets 0x204+0x20*N+4*k, with word k taken from bits 127-32k down to 96-32k. Other opcodes leave read data unchanged, and so do completions for other targets.
- R8: The window starts at CHAN_IDX*0x300 and covers offsets 0x000 to 0x3FF. Outside it, reads return zero and writes have no effect. Inside it, offsets that are not mapped also read zero and ignore writes.
- R9: An `rsp_ack` that arrives while no request is pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| req_valid | output | 1 | Request pending to back-end |
| req_opcode | output | 4 | Operation code |
| req_count_m1 | output | 4 | Payload bytes minus one |
| req_sid | output | 4 | Target id |
| req_addr | output | 16 | Target register address |
| req_wbytes | output | 128 | Write payload, first byte in top bits |
| rsp_ack | input | 1 | Back-end completion strobe |
| rsp_fail | input | 1 | Completion failed |
| rsp_rbytes | input | 128 | Returned bytes, first byte in top bits |

## Verification
Seeded random transactions cover all eleven opcodes, every byte count, random target ids and addresses, random payloads and random pass/fail results. A model of the per-target banks checks that read opcodes load their read-data words while write opcodes leave them alone. It also checks that a completion for one target leaves the status of others untouched. Directed cases cover these points:
- A command write with the start bit clear, which is told apart from an accepted start.
- Command and payload writes that arrive while a request is pending, which are told apart from idle writes.
- An acknowledge with nothing pending.
- Addresses just below and just beyond the window, and unmapped offsets inside it, which separate decoding inside the window from decoding outside it.

// File: rtl/pmic_cmd_pkg.sv
package pmic_cmd_pkg;
    localparam int CHAN_STRIDE = 'h300;
    localparam int WIN_SPAN    = 'h400;
    localparam int OFF_CMD     = 'h100;
    localparam int OFF_WD0     = 'h104;
    localparam int OFF_STAT    = 'h200;
    localparam int SLV_SHIFT   = 5;       // 0x20 bytes per target bank

    localparam int CMD_GO_BIT  = 31;
    localparam int CMD_OP_LSB  = 24;
    localparam int CMD_CNT_LSB = 20;
    localparam int CMD_SID_LSB = 16;
    localparam int FIELD_W     = 4;
    localparam int TADDR_W     = 16;

    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_FAIL_BIT = 2;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CMD,
        RK_WDATA,
        RK_STAT,
        RK_RDATA
    } reg_kind_e;

    function automatic logic op_is_read(input logic [FIELD_W-1:0] op);
        return (op == 4'd2) || (op == 4'd4) || (op == 4'd6);
    endfunction
endpackage

// File: rtl/pmic_addr_decode.sv
module pmic_addr_decode
    import pmic_cmd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CHAN_IDX = 1,
    parameter int NUM_SLV  = 16,
    localparam int SID_W   = $clog2(NUM_SLV)
) (
    input  logic [ADDR_W-1:0] paddr,
    output reg_kind_e         kind,
    output logic [1:0]        widx,
    output logic [SID_W-1:0]  sid
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CHAN_IDX * CHAN_STRIDE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(WIN_SPAN);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] WD0_A  = ADDR_W'(OFF_WD0);
    localparam logic [ADDR_W-1:0] WDL_A  = ADDR_W'(OFF_WD0 + 12);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(OFF_STAT);

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] wrel;
    logic [ADDR_W-1:0] srel;
    logic [4:0]        sub;
    logic [4:0]        sub_m4;
    logic              in_win;

    always_comb begin
        off    = paddr - BASE_A;
        in_win = (paddr >= BASE_A) && (off < SPAN_A);
        wrel   = off - WD0_A;
        srel   = off - STAT_A;
        sub    = srel[4:0];
        sub_m4 = sub - 5'd4;
        kind   = RK_NONE;
        widx   = '0;
        sid    = srel[SLV_SHIFT +: SID_W];
        if (in_win && off[1:0] == 2'b00) begin
            if (off == CMD_A) begin
                kind = RK_CMD;
            end else if (off >= WD0_A && off <= WDL_A) begin
                kind = RK_WDATA;
                widx = wrel[3:2];
            end else if (off >= STAT_A) begin
                if (sub == 5'd0) begin
                    kind = RK_STAT;
                end else if (sub <= 5'd16) begin
                    kind = RK_RDATA;
                    widx = sub_m4[3:2];
                end
            end
        end
    end
endmodule

// File: rtl/pmic_cmd_ctrl.sv
module pmic_cmd_ctrl
    import pmic_cmd_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    localparam int WIDX_W   = $clog2(NUM_WORDS),
    localparam int PAY_W    = NUM_WORDS * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  reg_kind_e         kind,
    input  logic [WIDX_W-1:0] widx,
    input  logic [31:0]       wdata_in,
    input  logic              rsp_ack,
    output logic              busy,
    output logic              start,
    output logic              fin,
    output logic [31:0]       cmd_word,
    output logic [31:0]       wdata_rd,
    output logic [PAY_W-1:0]  req_wbytes
);
    typedef struct packed {
        logic                       busy;
        logic [31:0]                cmd;
        logic [NUM_WORDS-1:0][31:0] wd;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        start = wr_acc && (kind == RK_CMD) && wdata_in[CMD_GO_BIT] && !st_q.busy;
        fin   = st_q.busy && rsp_ack;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cmd  = wdata_in;
        end
        if (fin) begin
            st_d.busy = 1'b0;
        end
        if (wr_acc && (kind == RK_WDATA) && !st_q.busy) begin
            st_d.wd[widx] = wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign cmd_word = st_q.cmd;
    assign wdata_rd = st_q.wd[widx];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_pay
        assign req_wbytes[PAY_W-1-32*g -: 32] = st_q.wd[g];
    end
endmodule

// File: rtl/pmic_slave_bank.sv
module pmic_slave_bank
    import pmic_cmd_pkg::*;
#(
    parameter int NUM_SLV   = 16,
    parameter int NUM_WORDS = 4,
    localparam int SID_W    = $clog2(NUM_SLV),
    localparam int WIDX_W   = $clog2(NUM_WORDS),
    localparam int PAY_W    = NUM_WORDS * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SID_W-1:0]  start_sid,
    input  logic              fin,
    input  logic [SID_W-1:0]  fin_sid,
    input  logic              fin_fail,
    input  logic              fin_is_read,
    input  logic [PAY_W-1:0]  fin_rbytes,
    input  logic [SID_W-1:0]  rd_sid,
    input  logic [WIDX_W-1:0] rd_widx,
    output logic [31:0]       rd_stat,
    output logic [31:0]       rd_word
);
    typedef struct packed {
        logic                       done;
        logic                       fail;
        logic [NUM_WORDS-1:0][31:0] rd;
    } slot_t;

    logic [NUM_SLV-1:0][31:0]                stat_flat;
    logic [NUM_SLV-1:0][NUM_WORDS-1:0][31:0] rd_flat;

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_slot
        slot_t s_d, s_q;

        always_comb begin
            s_d = s_q;
            if (start && start_sid == SID_W'(g)) begin
                s_d.done = 1'b0;
                s_d.fail = 1'b0;
            end
            if (fin && fin_sid == SID_W'(g)) begin
                s_d.done = 1'b1;
                s_d.fail = fin_fail;
                if (fin_is_read) begin
                    for (int w = 0; w < NUM_WORDS; w++) begin
                        s_d.rd[w] = fin_rbytes[PAY_W-1-32*w -: 32];
                    end
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        always_comb begin
            stat_flat[g] = '0;
            stat_flat[g][STAT_DONE_BIT] = s_q.done;
            stat_flat[g][STAT_FAIL_BIT] = s_q.fail;
        end
        assign rd_flat[g] = s_q.rd;
    end

    assign rd_stat = stat_flat[rd_sid];
    assign rd_word = rd_flat[rd_sid][rd_widx];
endmodule

// File: rtl/pmic_cmd_frontend.sv
module pmic_cmd_frontend
    import pmic_cmd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CHAN_IDX  = 1,
    parameter int NUM_SLV   = 16,
    parameter int NUM_WORDS = 4,
    localparam int SID_W    = $clog2(NUM_SLV),
    localparam int WIDX_W   = $clog2(NUM_WORDS),
    localparam int PAY_W    = NUM_WORDS * 32
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              req_valid,
    output logic [3:0]        req_opcode,
    output logic [3:0]        req_count_m1,
    output logic [3:0]        req_sid,
    output logic [15:0]       req_addr,
    output logic [PAY_W-1:0]  req_wbytes,
    input  logic              rsp_ack,
    input  logic              rsp_fail,
    input  logic [PAY_W-1:0]  rsp_rbytes
);
    reg_kind_e         kind;
    logic [1:0]        dec_widx;
    logic [SID_W-1:0]  dec_sid;
    logic              wr_acc;
    logic              busy;
    logic              start;
    logic              fin;
    logic [31:0]       cmd_word;
    logic [31:0]       wdata_rd;
    logic [31:0]       stat_rd;
    logic [31:0]       word_rd;

    assign wr_acc = psel && penable && pwrite;
    assign pready = 1'b1;

    pmic_addr_decode #(
        .ADDR_W  (ADDR_W),
        .CHAN_IDX(CHAN_IDX),
        .NUM_SLV (NUM_SLV)
    ) i_dec (
        .paddr(paddr),
        .kind (kind),
        .widx (dec_widx),
        .sid  (dec_sid)
    );

    pmic_cmd_ctrl #(
        .NUM_WORDS(NUM_WORDS)
    ) i_ctrl (
        .clk       (pclk),
        .rst_n     (presetn),
        .wr_acc    (wr_acc),
        .kind      (kind),
        .widx      (dec_widx[WIDX_W-1:0]),
        .wdata_in  (pwdata),
        .rsp_ack   (rsp_ack),
        .busy      (busy),
        .start     (start),
        .fin       (fin),
        .cmd_word  (cmd_word),
        .wdata_rd  (wdata_rd),
        .req_wbytes(req_wbytes)
    );

    assign req_valid    = busy;
    assign req_opcode   = cmd_word[CMD_OP_LSB  +: FIELD_W];
    assign req_count_m1 = cmd_word[CMD_CNT_LSB +: FIELD_W];
    assign req_sid      = cmd_word[CMD_SID_LSB +: FIELD_W];
    assign req_addr     = cmd_word[0 +: TADDR_W];

    pmic_slave_bank #(
        .NUM_SLV  (NUM_SLV),
        .NUM_WORDS(NUM_WORDS)
    ) i_bank (
        .clk        (pclk),
        .rst_n      (presetn),
        .start      (start),
        .start_sid  (pwdata[CMD_SID_LSB +: SID_W]),
        .fin        (fin),
        .fin_sid    (req_sid[SID_W-1:0]),
        .fin_fail   (rsp_fail),
        .fin_is_read(op_is_read(req_opcode)),
        .fin_rbytes (rsp_rbytes),
        .rd_sid     (dec_sid),
        .rd_widx    (dec_widx[WIDX_W-1:0]),
        .rd_stat    (stat_rd),
        .rd_word    (word_rd)
    );

    always_comb begin
        prdata = '0;
        if (psel) begin
            unique case (kind)
                RK_CMD:   prdata = cmd_word;
                RK_WDATA: prdata = wdata_rd;
                RK_STAT:  prdata = stat_rd;
                RK_RDATA: prdata = word_rd;
                default:  prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pmic_cmd_checker.sv
module pmic_cmd_checker
    import pmic_cmd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CHAN_IDX = 1,
    parameter int PAY_W    = 128
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic              req_valid,
    input logic [3:0]        req_opcode,
    input logic [3:0]        req_count_m1,
    input logic [3:0]        req_sid,
    input logic [15:0]       req_addr,
    input logic [PAY_W-1:0]  req_wbytes,
    input logic              rsp_ack
);
    localparam int BASE = CHAN_IDX * CHAN_STRIDE;
    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(BASE + OFF_CMD);

    logic go_write;
    logic outside;
    assign go_write = psel && penable && pwrite && (paddr == CMD_ADDR) && pwdata[CMD_GO_BIT];
    assign outside  = (int'(paddr) < BASE) || (int'(paddr) >= BASE + WIN_SPAN);

    a_r3_start_fields: assert property (@(posedge pclk) disable iff (!presetn)
        go_write && !req_valid |=> req_valid
            && req_sid == $past(pwdata[19:16]) && req_opcode == $past(pwdata[27:24])
            && req_count_m1 == $past(pwdata[23:20]) && req_addr == $past(pwdata[15:0]));

    a_r4_req_hold: assert property (@(posedge pclk) disable iff (!presetn)
        req_valid && !rsp_ack |=> req_valid);

    a_r4_req_drop: assert property (@(posedge pclk) disable iff (!presetn)
        req_valid && rsp_ack |=> !req_valid);

    a_r5_fields_stable: assert property (@(posedge pclk) disable iff (!presetn)
        req_valid && !rsp_ack |=> $stable(req_sid) && $stable(req_opcode)
            && $stable(req_count_m1) && $stable(req_addr) && $stable(req_wbytes));

    a_r8_outside_zero: assert property (@(posedge pclk) disable iff (!presetn)
        psel && outside |-> prdata == 32'h0);
endmodule

bind pmic_cmd_frontend pmic_cmd_checker #(
    .ADDR_W  (ADDR_W),
    .CHAN_IDX(CHAN_IDX),
    .PAY_W   (PAY_W)
) i_chk (
    .pclk        (pclk),
    .presetn     (presetn),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .pwdata      (pwdata),
    .prdata      (prdata),
    .req_valid   (req_valid),
    .req_opcode  (req_opcode),
    .req_count_m1(req_count_m1),
    .req_sid     (req_sid),
    .req_addr    (req_addr),
    .req_wbytes  (req_wbytes),
    .rsp_ack     (rsp_ack)
);

// File: tb/test_pmic_cmd_frontend.sv
module test_pmic_cmd_frontend;
    localparam logic [15:0] BASE = 16'h0300;

    logic         pclk = 1'b0;
    logic         presetn = 1'b0;
    logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [15:0]  paddr = '0;
    logic [31:0]  pwdata = '0;
    logic [31:0]  prdata;
    logic         pready;
    logic         req_valid;
    logic [3:0]   req_opcode, req_count_m1, req_sid;
    logic [15:0]  req_addr;
    logic [127:0] req_wbytes;
    logic         rsp_ack = 1'b0, rsp_fail = 1'b0;
    logic [127:0] rsp_rbytes = '0;

    int nchecks = 0;
    int nfail = 0;
    bit finished = 0;

    logic [31:0] m_stat [16];
    logic [31:0] m_rd   [16][4];
    logic [31:0] m_wd   [4];
    logic [31:0] m_cmd;

    always #10 pclk = ~pclk;

    pmic_cmd_frontend i_pmic_cmd_frontend (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .req_valid(req_valid), .req_opcode(req_opcode), .req_count_m1(req_count_m1),
        .req_sid(req_sid), .req_addr(req_addr), .req_wbytes(req_wbytes),
        .rsp_ack(rsp_ack), .rsp_fail(rsp_fail), .rsp_rbytes(rsp_rbytes)
    );

    function automatic logic [15:0] a_stat(input int s);
        return BASE + 16'h200 + 16'(s * 32);
    endfunction
    function automatic logic [15:0] a_rd(input int s, input int k);
        return BASE + 16'h204 + 16'(s * 32) + 16'(k * 4);
    endfunction
    function automatic logic [31:0] stat_val(input bit done, input bit fail);
        return {29'b0, fail, 1'b0, done};
    endfunction
    function automatic bit is_rd(input logic [3:0] op);
        return op == 4'd2 || op == 4'd4 || op == 4'd6;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1;
        chk(pready === 1'b1, "R2 pready", 128'(pready), 128'(1));
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        d = prdata;
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string rq);
        logic [31:0] v;
        apb_rd(a, v);
        chk(v === exp, rq, 128'(v), 128'(exp));
    endtask

    task automatic ack(input bit fail, input logic [127:0] rb);
        @(negedge pclk);
        rsp_ack = 1; rsp_fail = fail; rsp_rbytes = rb;
        @(negedge pclk);
        rsp_ack = 0;
    endtask

    task automatic run_txn(input logic [3:0] op, input logic [3:0] cnt, input logic [3:0] sid,
                           input logic [15:0] ta, input logic [127:0] wb,
                           input bit fail, input logic [127:0] rb, input bit poke_busy);
        logic [31:0] cw;
        int other;
        for (int k = 0; k < 4; k++) begin
            apb_wr(BASE + 16'h104 + 16'(4 * k), wb[127-32*k -: 32]);
            m_wd[k] = wb[127-32*k -: 32];
        end
        cw = {1'b1, 3'b0, op, cnt, sid, ta};
        apb_wr(BASE + 16'h100, cw);
        m_cmd = cw;
        m_stat[sid] = '0;
        chk(req_valid === 1'b1, "R3 req_valid", 128'(req_valid), 128'(1));
        chk({req_opcode, req_count_m1, req_sid, req_addr} === {op, cnt, sid, ta},
            "R3 fields", 128'({req_opcode, req_count_m1, req_sid, req_addr}), 128'({op, cnt, sid, ta}));
        chk(req_wbytes === wb, "R3 payload order", req_wbytes, wb);
        rd_chk(a_stat(int'(sid)), 32'h0, "R6 status cleared on start");
        if (poke_busy) begin
            apb_wr(BASE + 16'h100, ~cw | 32'h8000_0000);
            apb_wr(BASE + 16'h104, ~m_wd[0]);
            chk({req_opcode, req_count_m1, req_sid, req_addr} === {op, cnt, sid, ta},
                "R5 cmd while busy", 128'({req_opcode, req_sid, req_addr}), 128'({op, sid, ta}));
            rd_chk(BASE + 16'h104, m_wd[0], "R5 wdata while busy");
            rd_chk(BASE + 16'h100, m_cmd, "R5 cmd readback while busy");
            chk(req_valid === 1'b1, "R4 hold", 128'(req_valid), 128'(1));
        end
        ack(fail, rb);
        chk(req_valid === 1'b0, "R4 drop after ack", 128'(req_valid), 128'(0));
        m_stat[sid] = stat_val(1'b1, fail);
        if (is_rd(op)) for (int k = 0; k < 4; k++) m_rd[sid][k] = rb[127-32*k -: 32];
        rd_chk(a_stat(int'(sid)), m_stat[sid], "R6 status after ack");
        for (int k = 0; k < 4; k++) rd_chk(a_rd(int'(sid), k), m_rd[sid][k], "R7 read data");
        other = (int'(sid) + 1 + int'($urandom_range(0, 14))) % 16;
        rd_chk(a_stat(other), m_stat[other], "R6 other target status");
        rd_chk(a_rd(other, 0), m_rd[other][0], "R7 other target data");
    endtask

    initial begin
        repeat (150000) @(posedge pclk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchecks + 1, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h1bad5eed));
        for (int s = 0; s < 16; s++) begin
            m_stat[s] = '0;
            for (int k = 0; k < 4; k++) m_rd[s][k] = '0;
        end
        for (int k = 0; k < 4; k++) m_wd[k] = '0;
        m_cmd = '0;
        repeat (3) @(negedge pclk);
        presetn = 1;

        // R1 reset state
        chk(req_valid === 1'b0, "R1 req_valid", 128'(req_valid), 128'(0));
        rd_chk(BASE + 16'h100, 32'h0, "R1 cmd");
        rd_chk(BASE + 16'h110, 32'h0, "R1 wdata3");
        rd_chk(a_stat(0), 32'h0, "R1 status");
        rd_chk(a_rd(15, 3), 32'h0, "R1 read data");

        // R2 readback
        apb_wr(BASE + 16'h108, 32'hA5A5_1234);
        m_wd[1] = 32'hA5A5_1234;
        rd_chk(BASE + 16'h108, 32'hA5A5_1234, "R2 wdata1 readback");

        // R3 command without start bit has no effect
        apb_wr(BASE + 16'h100, 32'h0214_00FF);
        chk(req_valid === 1'b0, "R3 no start bit", 128'(req_valid), 128'(0));
        rd_chk(BASE + 16'h100, 32'h0, "R3 cmd unchanged");

        // R8 window edges and unmapped offsets
        apb_wr(16'h0104, 32'hDEAD_BEEF);
        rd_chk(BASE + 16'h104, m_wd[0], "R8 write below window");
        rd_chk(16'h0104, 32'h0, "R8 read below window");
        rd_chk(BASE + 16'h400, 32'h0, "R8 read past window");
        apb_wr(BASE + 16'h114, 32'h1111_2222);
        rd_chk(BASE + 16'h114, 32'h0, "R8 unmapped offset");
        rd_chk(BASE + 16'h000, 32'h0, "R8 unmapped low offset");

        // Directed: read with fail, write after it to same target, busy pokes
        run_txn(4'd2, 4'd15, 4'd3, 16'hBEEF, {4{32'h0102_0304}}, 1'b1,
                {32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC, 32'hDDEE_FF00}, 1'b1);
        run_txn(4'd1, 4'd0, 4'd3, 16'h0001, {4{32'hFFFF_0000}}, 1'b0, {4{32'hCAFE_F00D}}, 1'b1);
        run_txn(4'd6, 4'd7, 4'd15, 16'hFFFF, '0, 1'b0, {4{32'h7777_1111}}, 1'b0);

        // R9 ack while idle
        ack(1'b1, {4{32'hEEEE_EEEE}});
        rd_chk(a_stat(3), m_stat[3], "R9 idle ack status");
        rd_chk(a_rd(15, 0), m_rd[15][0], "R9 idle ack data");

        // Random transactions
        for (int i = 0; i < 60; i++) begin
            run_txn(4'($urandom_range(0, 10)), 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                    16'($urandom), {$urandom, $urandom, $urandom, $urandom}, 1'($urandom),
                    {$urandom, $urandom, $urandom, $urandom}, (i % 5) == 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end
endmodule